// File: doc/BRIEF.md
# SDRAM Full-Page Write Burst Sequencer

This block drives the command, address and data pins of an SDR SDRAM for one write burst in full-page mode. A request carries a bank, a row, a start column and a word count. The sequencer opens the row and waits the row-to-column delay. It then issues the write command with the start column and streams one word per clock from a ready/valid source. The column runs through the row and wraps past its last column. Because a full-page burst never stops by itself, the sequencer counts the words and ends the burst with BURST TERMINATE. It then holds off for write recovery before it precharges the bank, or leaves the row open if the PRECHARGE parameter is 0.

The delays are set as parameters in clock cycles. With the defaults (T_RCD=3, T_WR=3, COL_W=10, PRECHARGE=1), the write follows the row activation by three clocks and the precharge comes three clocks after the last data word.

Top module: `sdram_page_writer`

## Requirements
- R1: While rst_ni is low, sd_cke_o is low. After reset, sd_cke_o is high, the command bus shows NOP ({cs,ras,cas,we}=0111), busy_o is low and req_ready_o is high.
- R2: A request is accepted in a cycle where req_valid_i and req_ready_o are both high. In the next cycle the bus carries ACTIVE (0011) with req_bank_i on sd_ba_o and req_row_i on sd_addr_o.
- R3: WRITE (0100) comes exactly T_RCD cycles after ACTIVE. It carries the bank and the start column on sd_addr_o[COL_W-1:0], with sd_addr_o[10] low. The first data word is driven in the same cycle.
- R4: Each data cycle drives one word from wr_data_i, with sd_dq_oe_o and wr_ready_o high. Words go to consecutive columns with no gap, and the command bus shows NOP after the WRITE.
- R5: The column wraps modulo 2^COL_W within the row, so column 0 follows the last column.
- R6: Exactly the effective length of words is driven. BURST TERMINATE (0110) is issued in the cycle right after the last word.
- R7: A req_len_i of 0, or one greater than 2^COL_W, gives a burst of one full page (2^COL_W words).
- R8: In a data cycle where wr_valid_i is low, sd_dqm_o is high, so that column is not written. The column still advances.
- R9: With PRECHARGE=1, PRECHARGE (0010, sd_addr_o[10] low) goes to the same bank max(T_WR,2) cycles after the last data word.
- R10: busy_o is high from the ACTIVE cycle until the sequencer is back in idle, and req_ready_o is low over the same cycles. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Burst request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ADDR_W | Target row |
| req_col_i | input | COL_W | Start column |
| req_len_i | input | COL_W+2 | Word count (0 means full page) |
| wr_valid_i | input | 1 | Write word valid |
| wr_data_i | input | DATA_W | Write word |
| wr_ready_o | output | 1 | Word consumed this cycle |
| busy_o | output | 1 | Burst in progress |
| sd_cke_o | output | 1 | Clock enable |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | BANK_W | Bank address |
| sd_addr_o | output | ADDR_W | Row / column address |
| sd_dq_o | output | DATA_W | Data out |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dqm_o | output | 1 | Data mask |

## Verification
The bench models the memory and replays every write into a model array. This catches a design that writes the wrong column order, skips a word or writes one word too many. A burst that starts four columns before the end of the row shows whether the column wraps to 0. A design that carries into the row bits or leaves the row would put words at the wrong columns. Lengths of 0, 2000 and 1 test the clamp and the single-word edge. A wrong clamp gives a short burst or one that runs past a page, and an off-by-one terminate shows up as a moved BURST TERMINATE. A masked-data pattern checks that invalid cycles raise DQM without stalling the column. A request held high during a burst must not start a second ACTIVE. Bad timing to WRITE or to PRECHARGE shows up as a shifted cycle count.

// File: rtl/sdram_pw_pkg.sv
package sdram_pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_DATA, ST_BST, ST_WREC, ST_PRE
  } pw_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_BST   = 4'b0110,
    CMD_PRE   = 4'b0010
  } sd_cmd_e;
endpackage

// File: rtl/pw_down_cnt.sv
module pw_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (load_i)                cnt_o <= val_i;
    else if (dec_i && cnt_o != '0)  cnt_o <= cnt_o - 1'b1;
  end

  assign last_o = (cnt_o == W'(1));

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
endmodule

// File: rtl/pw_col_map.sv
module pw_col_map #(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [COL_W-1:0]  start_i,
  input  logic              adv_i,
  output logic [COL_W-1:0]  col_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     col_o <= '0;
    else if (load_i) col_o <= start_i;
    else if (adv_i)  col_o <= col_o + 1'b1; // natural wrap within the row
  end

  // column bits skip A10, which stays low (no auto-precharge)
  always_comb begin
    addr_o = '0;
    for (int i = 0; i < COL_W; i++) addr_o[(i < 10) ? i : i + 1] = col_o[i];
  end

  // R5
  col_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> col_o == COL_W'($past(col_o) + 1'b1));
endmodule

// File: rtl/sdram_page_writer.sv
module sdram_page_writer
  import sdram_pw_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 8,
  parameter int T_RCD     = 3,
  parameter int T_WR      = 3,
  parameter bit PRECHARGE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ADDR_W-1:0] req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [COL_W+1:0]  req_len_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              busy_o,
  output logic              sd_cke_o,
  output logic              sd_cs_no,
  output logic              sd_ras_no,
  output logic              sd_cas_no,
  output logic              sd_we_no,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ADDR_W-1:0] sd_addr_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  output logic              sd_dqm_o
);
  localparam int LEN_W   = COL_W + 2;
  localparam int PAGE    = 1 << COL_W;
  localparam int TWR_EFF = (T_WR < 2) ? 2 : T_WR;
  localparam int WR_GAP  = TWR_EFF - 2;
  localparam int WT_MAX  = (T_RCD > TWR_EFF) ? T_RCD : TWR_EFF;
  localparam int WT_W    = $clog2(WT_MAX + 1);

  pw_state_e         state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] row_q;
  logic              first_q, cke_q;
  logic [LEN_W-1:0]  len_eff;
  logic              accept;
  logic              wt_load, wt_dec, wt_last, wd_last;
  logic [WT_W-1:0]   wt_val, wt_cnt;
  logic [LEN_W-1:0]  wd_cnt;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] col_addr;
  sd_cmd_e           cmd;

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign len_eff = (req_len_i == '0 || req_len_i > LEN_W'(PAGE)) ? LEN_W'(PAGE) : req_len_i;

  always_comb begin
    state_d = state_q;
    wt_load = 1'b0;
    wt_val  = '0;
    wt_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ACT;
      ST_ACT: begin
        wt_load = 1'b1;
        wt_val  = WT_W'(T_RCD - 1);
        state_d = (T_RCD <= 1) ? ST_DATA : ST_RCD;
      end
      ST_RCD: begin
        wt_dec = 1'b1;
        if (wt_last) state_d = ST_DATA;
      end
      ST_DATA: if (wd_last) state_d = ST_BST;
      ST_BST: begin
        wt_load = 1'b1;
        wt_val  = WT_W'(WR_GAP);
        if (WR_GAP > 0)     state_d = ST_WREC;
        else if (PRECHARGE) state_d = ST_PRE;
        else                state_d = ST_IDLE;
      end
      ST_WREC: begin
        wt_dec = 1'b1;
        if (wt_last) state_d = PRECHARGE ? ST_PRE : ST_IDLE;
      end
      ST_PRE:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      first_q <= 1'b0;
      cke_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cke_q   <= 1'b1;
      if (accept) begin
        bank_q  <= req_bank_i;
        row_q   <= req_row_i;
        first_q <= 1'b1;
      end else if (state_q == ST_DATA) begin
        first_q <= 1'b0;
      end
    end
  end

  pw_down_cnt #(.W(WT_W)) u_wait (
    .clk_i, .rst_ni, .load_i(wt_load), .val_i(wt_val), .dec_i(wt_dec),
    .cnt_o(wt_cnt), .last_o(wt_last)
  );

  pw_down_cnt #(.W(LEN_W)) u_words (
    .clk_i, .rst_ni, .load_i(accept), .val_i(len_eff),
    .dec_i(state_q == ST_DATA), .cnt_o(wd_cnt), .last_o(wd_last)
  );

  pw_col_map #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_col (
    .clk_i, .rst_ni, .load_i(accept), .start_i(req_col_i),
    .adv_i(state_q == ST_DATA), .col_o(col), .addr_o(col_addr)
  );

  always_comb begin
    cmd       = CMD_NOP;
    sd_addr_o = '0;
    unique case (state_q)
      ST_ACT:  begin cmd = CMD_ACT; sd_addr_o = row_q; end
      ST_DATA: begin cmd = first_q ? CMD_WRITE : CMD_NOP; sd_addr_o = col_addr; end
      ST_BST:  cmd = CMD_BST;
      ST_PRE:  cmd = CMD_PRE; // A10 low: this bank only
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd;
  assign sd_cke_o    = cke_q;
  assign sd_ba_o     = bank_q;
  assign sd_dq_o     = wr_data_i;
  assign sd_dq_oe_o  = (state_q == ST_DATA);
  assign wr_ready_o  = (state_q == ST_DATA);
  assign sd_dqm_o    = (state_q != ST_DATA) || !wr_valid_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign req_ready_o = (state_q == ST_IDLE);

  // timing monitors for the checks below
  logic [$clog2(T_RCD+1)-1:0]   since_act;
  logic [$clog2(TWR_EFF+1)-1:0] since_dq;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '0;
      since_dq  <= '0;
    end else begin
      if (cmd == CMD_ACT) since_act <= 1;
      else if (since_act != T_RCD) since_act <= since_act + 1'b1;
      if (sd_dq_oe_o) since_dq <= 1;
      else if (since_dq != TWR_EFF) since_dq <= since_dq + 1'b1;
    end
  end

  // R2
  accept_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> cmd == CMD_ACT);
  // R3
  write_rcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_WRITE) |-> since_act >= T_RCD);
  // R6
  bst_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_BST) |-> $past(sd_dq_oe_o));
  // R9
  pre_recovery_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE) |-> (since_dq >= T_WR && !sd_dq_oe_o));
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> cmd == CMD_ACT);
endmodule

// File: tb/sdram_page_writer_test.sv
module sdram_page_writer_test;
  localparam int PAGE = 1024;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_bank = 0;
  logic [11:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic [11:0] req_len = 0;
  logic wr_valid = 0, wr_ready, busy;
  logic [7:0] wr_data = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, dq_oe, dqm;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [7:0] dq;

  int total = 0, bad = 0, cyc = 0;
  bit mask_on = 0;

  always #5 clk = ~clk;

  sdram_page_writer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_len_i(req_len),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready), .busy_o(busy),
    .sd_cke_o(cke), .sd_cs_no(cs_n), .sd_ras_no(ras_n), .sd_cas_no(cas_n), .sd_we_no(we_n),
    .sd_ba_o(ba), .sd_addr_o(addr), .sd_dq_o(dq), .sd_dq_oe_o(dq_oe), .sd_dqm_o(dqm)
  );

  function automatic logic [7:0] pat(int c);
    return 8'((c * 13 + 5) & 255);
  endfunction
  function automatic bit hole(int c);
    return (c % 4) == 1;
  endfunction

  // source: data and valid follow the cycle count
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    wr_data  = pat(cyc);
    wr_valid = !(mask_on && hole(cyc));
  end

  // bus model
  logic [7:0] mem [PAGE];
  bit         wflag [PAGE];
  int n_act, n_words, t_act, t_write, t_bst, t_pre, busy_cnt, cur_col;
  int act_bank, act_row, w_col, w_a10, w_bank, pre_bank, pre_a10;
  bit in_burst = 0;

  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    if (busy) busy_cnt++;
    if (c == 4'b0011) begin n_act++; t_act = cyc; act_bank = ba; act_row = addr; end
    if (c == 4'b0100) begin
      t_write = cyc; w_col = addr[9:0]; w_a10 = addr[10]; w_bank = ba;
      cur_col = addr[9:0]; in_burst = 1;
    end else if (in_burst && dq_oe) begin
      cur_col = (cur_col + 1) % PAGE;
    end
    if (in_burst && dq_oe) begin
      n_words++;
      if (!dqm) begin mem[cur_col] = dq; wflag[cur_col] = 1; end
    end
    if (c == 4'b0110) begin t_bst = cyc; in_burst = 0; end
    if (c == 4'b0010) begin t_pre = cyc; pre_bank = ba; pre_a10 = addr[10]; end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_burst(int bank, int row, int col, int len, bit mask, bit intrude, string tag);
    int l, wrong;
    for (int i = 0; i < PAGE; i++) begin mem[i] = 0; wflag[i] = 0; end
    n_act = 0; n_words = 0; busy_cnt = 0;
    t_act = -1; t_write = -1; t_bst = -1; t_pre = -1;
    mask_on = mask;
    @(posedge clk); #2;
    req_valid = 1; req_bank = 2'(bank); req_row = 12'(row); req_col = 10'(col); req_len = 12'(len);
    @(posedge clk); #2;
    req_valid = 0;
    if (intrude) begin
      repeat (6) @(posedge clk); #2;
      req_valid = 1; req_bank = 2'(bank + 1); req_row = 12'(row + 1);
      @(negedge clk);
      check(req_ready == 0, "R10 ready while busy", int'(req_ready), 0);
      repeat (5) @(posedge clk); #2;
      req_valid = 0;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    mask_on = 0;
    l = (len == 0 || len > PAGE) ? PAGE : len;
    check(n_act == 1, "R10 single ACTIVE", n_act, 1);
    check(act_bank == bank && act_row == row, "R2 ACTIVE bank/row", act_row, row);
    check(t_write - t_act == 3, "R3 ACTIVE to WRITE", t_write - t_act, 3);
    check(w_col == col && w_a10 == 0 && w_bank == bank, "R3 WRITE column", w_col, col);
    check(n_words == l, {tag, " word count"}, n_words, l);
    check(t_bst == t_write + l, "R6 BURST TERMINATE cycle", t_bst, t_write + l);
    wrong = 0;
    for (int k = 0; k < l; k++) begin
      int cc = (col + k) % PAGE;
      if (mask && hole(t_write + k)) begin
        if (wflag[cc]) wrong++;
      end else if (!wflag[cc] || mem[cc] != pat(t_write + k)) wrong++;
    end
    check(wrong == 0, {tag, " column contents"}, wrong, 0);
    check(t_pre == t_write + l - 1 + 3, "R9 PRECHARGE cycle", t_pre, t_write + l + 2);
    check(pre_bank == bank && pre_a10 == 0, "R9 PRECHARGE bank", pre_bank, bank);
    check(busy_cnt == t_pre - t_act + 1, "R10 busy span", busy_cnt, t_pre - t_act + 1);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(cke == 0, "R1 cke in reset", int'(cke), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(cke == 1, "R1 cke after reset", int'(cke), 1);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP", int'({cs_n, ras_n, cas_n, we_n}), 7);
    check(!busy && req_ready, "R1 idle flags", int'({busy, req_ready}), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    run_burst(1, 300, 10, 5, 0, 0, "R4");
    run_burst(2, 17, 1020, 8, 0, 0, "R5");
    run_burst(0, 5, 100, 24, 1, 0, "R8");
    run_burst(3, 4095, 0, 1, 0, 0, "R6");
    run_burst(1, 9, 500, 0, 0, 0, "R7");
    run_burst(2, 77, 3, 2000, 0, 0, "R7");
    run_burst(0, 40, 50, 30, 0, 1, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule